// File: doc/BRIEF.md
# Idle Clock Gating Controller

This block puts a small processor core into a low-power Idle state and brings it back out. When the core issues a power-save request, the controller removes the CPU clock. The oscillator keeps running, and every peripheral keeps its clock unless that peripheral's own stop-in-idle control bit asks for it to be gated too. Each peripheral has one such bit.

While Idle, the controller watches three kinds of wake source:

- interrupt requests, each qualified by its enable bit and by a priority compare against the core's current level;
- brown-out and external reset causes;
- a watchdog time-out.

The first qualifying event restores the CPU clock at the next clock edge, with no added delay. On that exit the controller pulses a wake indication and tells the core whether the wake came from an interrupt, which the core then services, or from some other cause, in which case the core resumes after the power-save instruction. Two sticky status flags record the exit and any watchdog time-out. Software clears these flags by writing zeros, and the power-on reset clears them.

Top module: `idle_gate_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `cpu_clk_en`=1, `idle_o`=0, both status flags are 0, `wake_o`=0, `wake_irq_o`=0 and every `periph_clk_en` bit is 1.
- R2: A `pwrsav_req` pulse seen while running, with no qualifying interrupt, makes `idle_o`=1 and `cpu_clk_en`=0 from the following clock edge until a wake.
- R3: While Idle, `periph_clk_en[i]` is 0 exactly when `periph_stop_idle[i]` is 1. While running, every bit is 1.
- R4: An interrupt qualifies only if its `irq_pend` and `irq_en` bits are both 1 and its 3-bit priority field (bits `i*3+2:i*3` of `irq_prio`) is strictly greater than `cpu_ipl`. A non-qualifying interrupt leaves the block Idle.
- R5: If a qualifying interrupt is pending when `pwrsav_req` arrives, Idle is not entered.
- R6: A qualifying interrupt during Idle gives, at the next edge, `cpu_clk_en`=1, `idle_o`=0, `idle_flag`=1 and `wake_irq_o`=1.
- R7: A `wdt_timeout` during Idle wakes the core and sets both `idle_flag` and `wdto_flag`, with `wake_irq_o`=0. A time-out while running sets `wdto_flag` only.
- R8: A `bor_rst` or `mclr_rst` pulse during Idle wakes the core and sets `idle_flag`. `wake_irq_o` stays 0 even if a qualifying interrupt is pending.
- R9: Power-on reset clears both status flags.
- R10: A `flag_wr` strobe clears each flag whose `flag_wdata` bit is 0 (bit 0 = Idle flag, bit 1 = watchdog flag) and leaves flags written with 1 unchanged. A hardware set in the same cycle wins over the clear.
- R11: `cpu_gclk` follows `clk` while the registered enable is 1 and stays low for whole periods while it is 0. The enable is captured during the low phase, so no partial pulse appears.
- R12: `wake_o` is a single-cycle pulse in the cycle after each exit from Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pwrsav_req | input | 1 | Request to enter Idle (one-cycle pulse) |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Per-interrupt enable bits |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed per-interrupt priorities |
| cpu_ipl | input | PRIO_W | Current core priority level |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| bor_rst | input | 1 | Brown-out reset cause pulse |
| mclr_rst | input | 1 | External master-clear reset cause pulse |
| periph_stop_idle | input | NUM_PERIPH | Per-peripheral stop-in-idle control bits |
| flag_wr | input | 1 | Software write strobe for the status flags |
| flag_wdata | input | 2 | Write data; 0 clears the flag |
| cpu_clk_en | output | 1 | Registered CPU clock enable |
| cpu_gclk | output | 1 | Glitch-free gated CPU clock |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| idle_o | output | 1 | Block is in Idle |
| idle_flag | output | 1 | Sticky Idle-exit status flag |
| wdto_flag | output | 1 | Sticky watchdog time-out flag |
| wake_o | output | 1 | One-cycle pulse after an Idle exit |
| wake_irq_o | output | 1 | The exit was caused by an interrupt |

## Verification
The hardest case to reach from the ports is the collision of events in the same cycle. Examples are a brown-out cause together with a pending qualifying interrupt while Idle, or a software clear arriving on the very edge that hardware sets the flag. The stimulus first parks the block in Idle with an interrupt held below the priority threshold. It then raises the competing inputs on one staged cycle. A reference model in the bench predicts cause priority, flag outcome and the gated-clock phase for every cycle. A priority sweep against a fixed level probes the strict-greater boundary.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;
  localparam int FLAG_IDLE = 0;
  localparam int FLAG_WDTO = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/idle_wake_qual.sv
module idle_wake_qual #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ-1:0]        en_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         ipl_i,
  output logic [NUM_IRQ-1:0]        hit_o,
  output logic                      any_o
);
  // an interrupt beats the core only when strictly above its level
  function automatic logic prio_beats(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] lvl);
    return p > lvl;
  endfunction

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign hit_o[g] = pend_i[g] & en_i[g] &
                      prio_beats(prio_i[g*PRIO_W +: PRIO_W], ipl_i);
  end

  assign any_o = |hit_o;
endmodule

// File: rtl/idle_sticky_flag.sv
module idle_sticky_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
    set_i |=> flag_o);
  // R10
  clr_takes_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/idle_clk_gate_cell.sv
module idle_clk_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent only while the clock is low, so the gate opens cleanly
  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/idle_gate_ctrl.sv
module idle_gate_ctrl #(
  parameter int NUM_IRQ    = 8,
  parameter int PRIO_W     = 3,
  parameter int NUM_PERIPH = 4
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      pwrsav_req,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         cpu_ipl,
  input  logic                      wdt_timeout,
  input  logic                      bor_rst,
  input  logic                      mclr_rst,
  input  logic [NUM_PERIPH-1:0]     periph_stop_idle,
  input  logic                      flag_wr,
  input  logic [1:0]                flag_wdata,
  output logic                      cpu_clk_en,
  output logic                      cpu_gclk,
  output logic [NUM_PERIPH-1:0]     periph_clk_en,
  output logic                      idle_o,
  output logic                      idle_flag,
  output logic                      wdto_flag,
  output logic                      wake_o,
  output logic                      wake_irq_o
);
  import idle_gate_pkg::*;

  // named internal events
  logic [NUM_IRQ-1:0]   irq_hit;
  logic                 qual_any;
  logic                 rst_cause;
  logic                 wake_any;
  logic                 wake_by_irq;
  logic                 enter_idle;
  logic                 idle_next;
  logic                 in_idle_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;

  idle_wake_qual #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_qual (
    .pend_i (irq_pend),
    .en_i   (irq_en),
    .prio_i (irq_prio),
    .ipl_i  (cpu_ipl),
    .hit_o  (irq_hit),
    .any_o  (qual_any)
  );

  assign rst_cause   = bor_rst | mclr_rst;
  assign wake_any    = in_idle_q & (qual_any | wdt_timeout | rst_cause);
  assign wake_by_irq = wake_any & qual_any & ~rst_cause;
  assign enter_idle  = ~in_idle_q & pwrsav_req & ~qual_any;
  assign idle_next   = in_idle_q ? ~wake_any : enter_idle;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      in_idle_q  <= 1'b0;
      cpu_clk_en <= 1'b1;
      wake_o     <= 1'b0;
      wake_irq_o <= 1'b0;
    end else begin
      in_idle_q  <= idle_next;
      cpu_clk_en <= ~idle_next;
      wake_o     <= wake_any;
      wake_irq_o <= wake_by_irq;
    end
  end

  assign idle_o = in_idle_q;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
    assign periph_clk_en[p] = ~(in_idle_q & periph_stop_idle[p]);
  end

  assign flag_set[FLAG_IDLE] = wake_any;
  assign flag_set[FLAG_WDTO] = wdt_timeout;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    assign flag_clr[f] = flag_wr & ~flag_wdata[f];
    idle_sticky_flag u_flag (
      .clk    (clk),
      .por_n  (por_n),
      .set_i  (flag_set[f]),
      .clr_i  (flag_clr[f]),
      .flag_o (flag_q[f])
    );
  end

  assign idle_flag = flag_q[FLAG_IDLE];
  assign wdto_flag = flag_q[FLAG_WDTO];

  idle_clk_gate_cell u_gate (
    .clk_i  (clk),
    .en_i   (cpu_clk_en),
    .gclk_o (cpu_gclk)
  );

  // R2
  enter_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!idle_o && pwrsav_req && !qual_any) |=> (idle_o && !cpu_clk_en));
  // R5
  pend_blocks_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!idle_o && qual_any) |=> (!idle_o && cpu_clk_en));
  // R4
  stay_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idle_o && !qual_any && !wdt_timeout && !rst_cause) |=> idle_o);
  // R6
  irq_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idle_o && qual_any && !rst_cause) |=> (cpu_clk_en && wake_irq_o && idle_flag));
  // R7
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idle_o && wdt_timeout) |=> (idle_flag && wdto_flag && cpu_clk_en));
  // R8
  rst_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idle_o && rst_cause) |=> (!wake_irq_o && idle_flag && !idle_o));
  // R12
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    wake_o |=> !wake_o);
endmodule

// File: tb/idle_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_gate_ctrl_tb_top;
  localparam int NI = 8;
  localparam int PW = 3;
  localparam int NP = 4;

  typedef struct {
    string       tag;
    logic [10:0] exp;
  } sb_item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              por_n = 1'b0;
  logic              pwrsav_req = 0, wdt_timeout = 0, bor_rst = 0, mclr_rst = 0, flag_wr = 0;
  logic [NI-1:0]     irq_pend = '0, irq_en = '0;
  logic [NI*PW-1:0]  irq_prio = '0;
  logic [PW-1:0]     cpu_ipl = '0;
  logic [NP-1:0]     periph_stop_idle = '0;
  logic [1:0]        flag_wdata = '0;
  logic              cpu_clk_en, cpu_gclk, idle_o, idle_flag, wdto_flag, wake_o, wake_irq_o;
  logic [NP-1:0]     periph_clk_en;

  idle_gate_ctrl #(.NUM_IRQ(NI), .PRIO_W(PW), .NUM_PERIPH(NP)) dut_i (
    .clk(clk), .por_n(por_n), .pwrsav_req(pwrsav_req), .irq_pend(irq_pend),
    .irq_en(irq_en), .irq_prio(irq_prio), .cpu_ipl(cpu_ipl),
    .wdt_timeout(wdt_timeout), .bor_rst(bor_rst), .mclr_rst(mclr_rst),
    .periph_stop_idle(periph_stop_idle), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .cpu_clk_en(cpu_clk_en), .cpu_gclk(cpu_gclk), .periph_clk_en(periph_clk_en),
    .idle_o(idle_o), .idle_flag(idle_flag), .wdto_flag(wdto_flag),
    .wake_o(wake_o), .wake_irq_o(wake_irq_o)
  );

  // staged stimulus, copied to the pins at the next falling edge
  logic             s_req = 0, s_wdt = 0, s_bor = 0, s_mclr = 0, s_wr = 0;
  logic [NI-1:0]    s_pend = '0, s_en = '0;
  logic [NI*PW-1:0] s_prio = '0;
  logic [PW-1:0]    s_ipl = '0;
  logic [NP-1:0]    s_sidl = '0;
  logic [1:0]       s_wd = '0;

  // reference model state
  logic m_idle = 0, m_if = 0, m_wf = 0;

  sb_item_t sbq[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input string tag);
    logic qual, wake, prev_en, nidle, wirq;
    sb_item_t it;
    @(negedge clk);
    pwrsav_req = s_req; wdt_timeout = s_wdt; bor_rst = s_bor; mclr_rst = s_mclr;
    flag_wr = s_wr; flag_wdata = s_wd; irq_pend = s_pend; irq_en = s_en;
    irq_prio = s_prio; cpu_ipl = s_ipl; periph_stop_idle = s_sidl;
    qual = 1'b0;
    for (int i = 0; i < NI; i++)
      if (s_pend[i] && s_en[i] && (s_prio[i*PW +: PW] > s_ipl)) qual = 1'b1;
    wake    = m_idle && (qual || s_wdt || s_bor || s_mclr);
    prev_en = !m_idle;
    nidle   = m_idle ? !wake : (s_req && !qual);
    if (wake) m_if = 1'b1; else if (s_wr && !s_wd[0]) m_if = 1'b0;
    if (s_wdt) m_wf = 1'b1; else if (s_wr && !s_wd[1]) m_wf = 1'b0;
    wirq   = wake && qual && !s_bor && !s_mclr;
    m_idle = nidle;
    it.tag = tag;
    it.exp = {prev_en, !nidle, nidle, m_if, m_wf, wake, wirq, ~(s_sidl & {NP{nidle}})};
    sbq.push_back(it);
    s_req = 0; s_wdt = 0; s_bor = 0; s_mclr = 0; s_wr = 0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    pwrsav_req = 0; wdt_timeout = 0; bor_rst = 0; mclr_rst = 0; flag_wr = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    m_idle = 0; m_if = 0; m_wf = 0;
  endtask

  // monitor: the gated clock is sampled in the high phase (R11)
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      sb_item_t it;
      logic [10:0] obs;
      it  = sbq.pop_front();
      obs = {cpu_gclk, cpu_clk_en, idle_o, idle_flag, wdto_flag, wake_o, wake_irq_o, periph_clk_en};
      n_vec++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b (gclk,en,idle,if,wf,wake,wirq,periph)",
                 it.tag, obs, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_por();
    step("R1"); step("R1");

    // enter Idle with half the peripherals stopping
    s_sidl = 4'b0101; s_req = 1; step("R2");
    step("R3"); step("R11");

    // non-qualifying interrupts: disabled, then priority equal to the level
    s_pend = 8'h08; s_en = 8'h00; s_prio[3*PW +: PW] = 3'd7; s_ipl = 3'd2; step("R4");
    s_en = 8'h08; s_prio[3*PW +: PW] = 3'd2; step("R4");
    s_ipl = 3'd1; step("R6");
    s_pend = '0; step("R12"); step("R11");

    // qualifying request already pending at the power-save request
    s_pend = 8'h08; s_req = 1; step("R5");
    s_pend = '0; step("R5");

    // watchdog while running and while Idle
    s_wdt = 1; step("R7");
    s_req = 1; step("R2");
    s_wdt = 1; step("R7"); step("R12");

    // software clears, then clear colliding with a hardware set
    s_wr = 1; s_wd = 2'b01; step("R10");
    s_wr = 1; s_wd = 2'b11; step("R10");
    s_wr = 1; s_wd = 2'b00; step("R10");
    s_req = 1; step("R2");
    s_pend = 8'h08; s_wr = 1; s_wd = 2'b00; step("R10");
    s_pend = '0; step("R10");

    // reset causes during Idle, one with a qualifying interrupt present
    s_req = 1; step("R2");
    s_pend = 8'h08; s_bor = 1; step("R8");
    s_pend = '0; step("R8");
    s_wr = 1; s_wd = 2'b00; step("R10");
    s_sidl = 4'b1110; s_req = 1; step("R3");
    s_mclr = 1; step("R8");

    // power-on reset clears flags
    s_wdt = 1; step("R9");
    do_por();
    step("R9"); step("R1");

    // priority sweep against a fixed level of 3
    s_ipl = 3'd3; s_en = 8'h01;
    for (int p = 0; p < 8; p++) begin
      s_pend = '0; s_req = 1; step("R2");
      s_pend = 8'h01; s_prio[0 +: PW] = p[PW-1:0]; step("R4");
      s_pend = '0; step("R12");
      s_bor = 1; step("R8");
      step("R12");
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule